// File: doc/BRIEF.md
# Dual External Interrupt Trigger Unit

This block watches two active-low interrupt pins, each idle high, and turns activity on them into service requests for a CPU-side interrupt arbiter. Each pin is resynchronised with a two-flop chain. Software picks, per channel, whether a request is the live low level on the pin or a latched falling edge. Software also sets a per-channel enable. A one-bit-address byte bus reaches two registers: a control/status register that holds the type-select bits and the edge flags, and an enable register.

Requests leave the block on a valid/ready-style channel. `req_valid` carries a 16-bit vector address, and `req_ack` acts as ready. Once `req_valid` rises, it and `req_vector` hold until a cycle in which `req_ack` is high, and that cycle is the handshake. A handshake clears the edge flag of the channel being serviced. After the handshake the block offers nothing more until a `reti` pulse marks the return from the service routine. If channel 0 is still pending after `reti`, it is offered again. When both channels are pending at the same time, channel 0 goes first. Asserting `req_ack` while `req_valid` is low does nothing, and so does `reti` outside service.

Register map. Address 0 is control/status: bit 0 is the type of channel 0, bit 1 is the flag of channel 0, bit 2 is the type of channel 1, and bit 3 is the flag of channel 1. A type of 0 means low-level triggering and 1 means falling-edge triggering. Address 1 is enable: bit 0 enables channel 0 and bit 1 enables channel 1. Unused bits read as 0.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset both type bits, both flags and both enables are 0, `req_valid` is low, and both registers read 0x00.
- R2: A write to address 0 updates only bits 0..3, and a write to address 1 updates only bits 0..1. All other bits read back as 0, and `bus_rdata` shows the register selected by `bus_addr` in the same cycle.
- R3: In level mode (type 0), an enabled channel whose pin is held low raises `req_valid` on the third rising clock edge after the pin first reads low. The flag bit stays 0.
- R4: In edge mode (type 1), a high-to-low pin transition sets the channel flag on the third rising edge after the low is sampled, even if the pin is high again by then. The request follows one edge later.
- R5: The handshake (`req_valid` and `req_ack` high together) clears the flag of the channel being serviced. A flag cleared this way raises no further request.
- R6: In level mode, if the pin is still low when `reti` is taken, the same vector is offered again on the next edge. If the pin was released before that, nothing is offered.
- R7: A channel whose enable bit is 0 raises no request. Its flag still latches edges, and the request appears once the channel is enabled.
- R8: Channel 0 presents vector 0x0003 and channel 1 presents vector 0x0013.
- R9: With both channels pending, channel 0 is offered first. `req_valid` and `req_vector` hold steady until the handshake.
- R10: Software may write the flag bits, and a flag written to 1 in edge mode raises a request. If a hardware edge set and a software write of 0 land in the same cycle, the flag ends at 1.
- R11: From the handshake until `reti`, `req_valid` stays low, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 2 | Active-low interrupt pins, bit 0 = channel 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select (0 control/status, 1 enable) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| req_valid | output | 1 | Request offered to the CPU |
| req_vector | output | 16 | Vector address of the offered channel |
| req_ack | input | 1 | Vector acknowledge; acts as ready |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
Two updates can land on the same edge flag in one cycle: the hardware set from a detected falling edge, and a software write of 0 through the register bus. The bench provokes the collision by driving a pin low and then issuing the clearing write so that it lands on exactly the edge where the synchronised falling edge is detected. The flag is judged by reading it back; it must read 1. The handshake clear and a fresh edge set also contend for the flag. The reference model scores every cycle of these scenarios against the outputs.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NCH    = 2;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 16;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_OFFER   = 2'd1,
    ARB_SERVICE = 2'd2
  } arb_state_e;

  // control/status bit positions; a neighbour decodes these
  function automatic int type_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int flag_pos(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic logic [VEC_W-1:0] chan_vector(input int ch);
    return (ch == 0) ? 16'h0003 : 16'h0013;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], pin_n};
  end

  assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic wr_en,
  input  logic wr_type,
  input  logic wr_flag,
  input  logic svc_clr,
  output logic type_o,
  output logic flag_o,
  output logic fall_o,
  output logic pend_o
);
  logic prev_q;
  logic type_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign fall_o = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) type_q <= wr_type;
      // hardware edge set beats service clear beats software write
      if (type_q && fall_o) flag_q <= 1'b1;
      else if (svc_clr)     flag_q <= 1'b0;
      else if (wr_en)       flag_q <= wr_flag;
    end
  end

  assign type_o = type_q;
  assign flag_o = flag_q;
  assign pend_o = type_q ? flag_q : ~pin_s;
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  input  logic             ack,
  input  logic             reti,
  output logic             valid,
  output logic [VEC_W-1:0] vector,
  output logic [N-1:0]     svc_clr
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  arb_state_e       state_q;
  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] pick;
  logic             any_pend;

  always_comb begin
    pick     = '0;
    any_pend = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick     = IDX_W'(i);
        any_pend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      sel_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (any_pend) begin
          state_q <= ARB_OFFER;
          sel_q   <= pick;
        end
        ARB_OFFER:   if (ack)  state_q <= ARB_SERVICE;
        ARB_SERVICE: if (reti) state_q <= ARB_IDLE;
        default:               state_q <= ARB_IDLE;
      endcase
    end
  end

  assign valid = (state_q == ARB_OFFER);

  always_comb begin
    vector = '0;
    for (int i = 0; i < N; i++)
      if (sel_q == IDX_W'(i)) vector = chan_vector(i);
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_clr
      assign svc_clr[g] = valid && ack && (sel_q == IDX_W'(g));
    end
  endgenerate
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    irq_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  input  logic              req_ack,
  input  logic              reti
);
  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] type_q;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] fall_q;
  logic [NCH-1:0] pend_raw;
  logic [NCH-1:0] svc_clr;
  logic [NCH-1:0] en_q;
  logic           wr_ctrl;
  logic           wr_en_reg;

  assign wr_ctrl   = bus_wr && !bus_addr;
  assign wr_en_reg = bus_wr &&  bus_addr;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (irq_n[c]),
        .pin_s (pin_s[c])
      );

      ext_irq_chan u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s   (pin_s[c]),
        .wr_en   (wr_ctrl),
        .wr_type (bus_wdata[type_pos(c)]),
        .wr_flag (bus_wdata[flag_pos(c)]),
        .svc_clr (svc_clr[c]),
        .type_o  (type_q[c]),
        .flag_o  (flag_q[c]),
        .fall_o  (fall_q[c]),
        .pend_o  (pend_raw[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= bus_wdata[NCH-1:0];
  end

  ext_irq_arb #(.N(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend_raw & en_q),
    .ack     (req_ack),
    .reti    (reti),
    .valid   (req_valid),
    .vector  (req_vector),
    .svc_clr (svc_clr)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata[NCH-1:0] = en_q;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bus_rdata[type_pos(c)] = type_q[c];
        bus_rdata[flag_pos(c)] = flag_q[c];
      end
    end
  end
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ack,
  input logic [15:0] req_vector,
  input logic [1:0]  en_q,
  input logic [1:0]  type_q,
  input logic [1:0]  flag_q,
  input logic [1:0]  fall_q,
  input logic        bus_wr,
  input logic        bus_addr,
  input logic [7:0]  bus_wdata
);
  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_vector)));

  p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vector == 16'h0003 || req_vector == 16'h0013));

  p_quiet_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);

  p_gate_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_vector == 16'h0003) |-> $past(en_q[0]));

  p_gate_ch1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_vector == 16'h0013) |-> $past(en_q[1]));

  p_hw_set_wins_ch0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (type_q[0] && fall_q[0]) |=> flag_q[0]);

  p_hw_set_wins_ch1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (type_q[1] && fall_q[1]) |=> flag_q[1]);

  p_ack_clears_ch0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && req_vector == 16'h0003 && !fall_q[0])
      |=> !flag_q[0]);

  p_level_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!type_q[0] && !flag_q[0] && !(bus_wr && !bus_addr && bus_wdata[1]))
      |=> !flag_q[0]);
endmodule

bind ext_irq_unit ext_irq_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ack    (req_ack),
  .req_vector (req_vector),
  .en_q       (en_q),
  .type_q     (type_q),
  .flag_q     (flag_q),
  .fall_q     (fall_q),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata)
);

// File: tb/ext_irq_unit_bench.sv
module ext_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  irq_n = 2'b11;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        req_valid;
  logic [15:0] req_vector;
  logic        req_ack = 1'b0;
  logic        reti = 1'b0;

  int    compared = 0;
  int    mismatched = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  ext_irq_unit u_ext_irq_unit (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .req_valid(req_valid), .req_vector(req_vector),
    .req_ack(req_ack), .reti(reti)
  );

  // ---------------- behavioural reference model ----------------
  bit m_hist[2][$];           // raw pin samples, newest first
  bit m_type[2], m_flag[2], m_en[2];
  int m_mode = 0;             // 0 waiting, 1 offering, 2 in service
  int m_ch = 0;

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_hist[c] = {1'b1, 1'b1, 1'b1};
      m_type[c] = 0; m_flag[c] = 0; m_en[c] = 0;
    end
    m_mode = 0; m_ch = 0;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit now_lvl[2], fell[2], want[2];
      bit nt[2], nf[2], ne[2];
      int nmode, nch;
      for (int c = 0; c < 2; c++) begin
        now_lvl[c] = m_hist[c][1];
        fell[c]    = m_hist[c][2] && !m_hist[c][1];
        want[c]    = m_en[c] && (m_type[c] ? m_flag[c] : !now_lvl[c]);
      end
      nmode = m_mode; nch = m_ch;
      for (int c = 0; c < 2; c++) begin
        nt[c] = m_type[c]; nf[c] = m_flag[c]; ne[c] = m_en[c];
        if (bus_wr && bus_addr == 1'b0) nt[c] = bus_wdata[2*c];
        if (bus_wr && bus_addr == 1'b1) ne[c] = bus_wdata[c];
        if (m_type[c] && fell[c]) nf[c] = 1;
        else if (m_mode == 1 && req_ack && m_ch == c) nf[c] = 0;
        else if (bus_wr && bus_addr == 1'b0) nf[c] = bus_wdata[2*c+1];
      end
      case (m_mode)
        0: if (want[0] || want[1]) begin nmode = 1; nch = want[0] ? 0 : 1; end
        1: if (req_ack) nmode = 2;
        default: if (reti) nmode = 0;
      endcase
      for (int c = 0; c < 2; c++) begin
        m_hist[c].push_front(irq_n[c]);
        void'(m_hist[c].pop_back());
        m_type[c] = nt[c]; m_flag[c] = nf[c]; m_en[c] = ne[c];
      end
      m_mode = nmode; m_ch = nch;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [7:0]  e_rd;
    logic [15:0] e_vec;
    e_rd  = bus_addr ? {6'b0, m_en[1], m_en[0]}
                     : {4'b0, m_flag[1], m_type[1], m_flag[0], m_type[0]};
    e_vec = (m_ch == 0) ? 16'h0003 : 16'h0013;
    compared++;
    if (req_valid !== (m_mode == 1) || bus_rdata !== e_rd ||
        ((m_mode == 1) && req_vector !== e_vec)) begin
      mismatched++;
      $display("FAIL %s cycle compare: valid=%0b vec=%h rd=%h expected valid=%0b vec=%h rd=%h",
               phase, req_valid, req_vector, bus_rdata, (m_mode == 1), e_vec, e_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic pulse_ack();
    req_ack = 1; tick(); req_ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic expect_rd(input logic a, input logic [7:0] e, input string tag);
    bus_addr = a; #1;
    compared++;
    if (bus_rdata !== e) begin
      mismatched++;
      $display("FAIL %s read addr %0d: got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic expect_req(input logic v, input logic [15:0] e, input string tag);
    compared++;
    if (req_valid !== v || (v && req_vector !== e)) begin
      mismatched++;
      $display("FAIL %s request: got valid=%0b vec=%h expected valid=%0b vec=%h",
               tag, req_valid, req_vector, v, e);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    tick(3); rst_n = 1; tick();
    expect_rd(0, 8'h00, "R1"); expect_rd(1, 8'h00, "R1"); expect_req(0, 0, "R1");

    // R2 register map
    phase = "R2";
    reg_write(1, 8'hFF); expect_rd(1, 8'h03, "R2");
    reg_write(0, 8'hF5); expect_rd(0, 8'h05, "R2");
    reg_write(0, 8'h00); expect_rd(0, 8'h00, "R2");

    // R3 level request, R11 silence in service, R6 re-request
    phase = "R3";
    irq_n[0] = 0; tick(2); expect_req(0, 0, "R3");
    tick(); expect_req(1, 16'h0003, "R3"); expect_rd(0, 8'h00, "R3");
    phase = "R11";
    pulse_ack(); expect_req(0, 0, "R11");
    tick(3); expect_req(0, 0, "R11");
    phase = "R6";
    pulse_reti(); tick(); expect_req(1, 16'h0003, "R6");
    irq_n[0] = 1; pulse_ack(); tick(3); pulse_reti(); tick(3);
    expect_req(0, 0, "R6");

    // R4 edge latch, R5 clear on handshake
    phase = "R4";
    reg_write(0, 8'h01);
    irq_n[0] = 0; tick(2); irq_n[0] = 1; expect_req(0, 0, "R4");
    tick(); expect_rd(0, 8'h03, "R4");
    tick(); expect_req(1, 16'h0003, "R4");
    phase = "R5";
    pulse_ack(); expect_rd(0, 8'h01, "R5");
    pulse_reti(); tick(2); expect_req(0, 0, "R5");

    // R7 enable gating, R8 channel 1 vector
    phase = "R7";
    reg_write(1, 8'h01); reg_write(0, 8'h04);
    irq_n[1] = 0; tick(4); irq_n[1] = 1;
    expect_rd(0, 8'h0C, "R7"); expect_req(0, 0, "R7");
    phase = "R8";
    reg_write(1, 8'h03); tick(); expect_req(1, 16'h0013, "R8");
    pulse_ack(); expect_rd(0, 8'h04, "R5");
    pulse_reti(); tick(2);

    // R9 both pending: channel 0 first, held until handshake
    phase = "R9";
    reg_write(0, 8'h00);
    irq_n = 2'b00; tick(3); expect_req(1, 16'h0003, "R9");
    tick(4); expect_req(1, 16'h0003, "R9");
    pulse_ack(); irq_n[0] = 1; tick(3); pulse_reti(); tick();
    expect_req(1, 16'h0013, "R9");
    pulse_ack(); irq_n[1] = 1; tick(3); pulse_reti(); tick(2);
    expect_req(0, 0, "R9");

    // R10 software flag set, then hardware set vs software clear
    phase = "R10";
    reg_write(0, 8'h03); tick(); expect_req(1, 16'h0003, "R10");
    pulse_ack(); pulse_reti(); tick(2);
    reg_write(1, 8'h01); reg_write(0, 8'h04);
    irq_n[1] = 0; tick(2);
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h04; tick(); bus_wr = 0;
    expect_rd(0, 8'h0C, "R10");
    irq_n[1] = 1; tick(3);
    reg_write(0, 8'h00); expect_rd(0, 8'h00, "R10");
    reg_write(1, 8'h00); tick(4); expect_req(0, 0, "R10");

    summary();
  end
endmodule